// File: doc/BRIEF.md
# Reversible In-Place 8-Bit Arithmetic Unit

This unit applies one of a small set of operations to a target register `b` and keeps every other operand as it was. Each operation is a bijection on the operands: no bit of information is lost, and each one has an exact inverse that a reverse flag selects. Addition uses a ripple of majority and unmajority stages that share one ancilla carry bit. Subtraction is not a separate circuit. It is the same stage network run backwards, with each stage replaced by its inverse and the stage order reversed.

Arithmetic wraps modulo 2^W. No carry-out is exposed, because it would break the bijection. The results come from a combinational datapath. When `REG_OUT` is 1 (the default), a reset-cleared register stage sits on the outputs and gives one cycle of latency. This stage is the only state in the block, so the block has no sequencer. A caller undoes an operation by issuing the same opcode again with the reverse flag flipped.

Top module: `rev_alu`

## Requirements
- R1: Opcode 0 (add) with rev_i=0 sets b_o = (a_i + b_i + anc_i) mod 2^W.
- R2: Opcode 0 with rev_i=1 sets b_o = (b_i - a_i - anc_i) mod 2^W, the exact inverse of R1.
- R3: Opcode 1 (negate) sets b_o = (-b_i) mod 2^W for both values of rev_i.
- R4: Opcode 2 (step) sets b_o = b_i + 1 when rev_i=0 and b_o = b_i - 1 when rev_i=1, modulo 2^W.
- R5: Opcode 3 (rotate) rotates b_i left by one bit when rev_i=0 and right by one bit when rev_i=1.
- R6: Opcode 4 (word Toffoli) sets b_o = b_i XOR (a_i AND c_i) bitwise, and rev_i has no effect on it.
- R7: For every opcode, a_o equals a_i and c_o equals c_i.
- R8: anc_o always equals anc_i. err_o is 1 exactly when the opcode is 0 and anc_o is 1.
- R9: Opcodes 5, 6 and 7 leave b unchanged (b_o = b_i) and keep err_o at 0.
- R10: For opcodes 0 to 4, issuing an operation and then issuing the same opcode with rev_i inverted on the result restores the original b.
- R11: With REG_OUT=1, outputs appear one clock after their inputs. While rst_n is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register stage |
| rst_n | input | 1 | Asynchronous active-low reset of the output stage |
| op_i | input | 3 | Operation code |
| rev_i | input | 1 | 1 selects the inverse of the operation |
| anc_i | input | 1 | Ancilla carry bit, expected to be 0 |
| a_i | input | W | Control operand, passed through unchanged |
| b_i | input | W | Target operand |
| c_i | input | W | Second control operand for the word Toffoli |
| a_o | output | W | Control operand after the operation |
| b_o | output | W | Updated target |
| c_o | output | W | Second control operand after the operation |
| anc_o | output | 1 | Ancilla bit on exit |
| err_o | output | 1 | Add was issued with a nonzero ancilla |

## Verification
Both adder directions are swept over every value of a against a strided set of b values. This covers wrap-around, all-ones carry chains and the zero operand. Any stage that is wrong in only one direction shows up as a mismatch between the forward sum and the reverse difference. The single-operand operations are tried on all 256 values of b in both directions, so a rotate in the wrong direction or an off-by-one step is caught. The Toffoli and the unused opcodes are tried with complementary masks and with rev_i set. Round trips then run forward and reverse back to back on mixed patterns to confirm each operation is its own exact inverse. A nonzero ancilla is also applied, to confirm the offset result and the error flag.

// File: rtl/rev_alu_pkg.sv
package rev_alu_pkg;
    localparam int OPW = 3;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 3'd0,
        OP_NEG  = 3'd1,
        OP_STEP = 3'd2,
        OP_ROT  = 3'd3,
        OP_TOF  = 3'd4,
        OP_RSV5 = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } ralu_op_e;
endpackage

// File: rtl/rev_maj_adder.sv
// In-place ripple adder built from majority / unmajority stages.
// Register image: ext[0] is the ancilla, ext[i+1] holds a[i]; t holds b.
module rev_maj_adder #(
    parameter int W = 8
) (
    input  logic         rev_i,
    input  logic         anc_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         anc_o,
    output logic [W-1:0] a_o,
    output logic [W-1:0] b_o
);
    localparam int EW = W + 1;

    logic [EW-1:0] ext;
    logic [W-1:0]  t;

    always_comb begin
        ext = {a_i, anc_i};
        t   = b_i;
        if (!rev_i) begin
            // majority sweep upward: carry lands in the a slot
            for (int i = 0; i < W; i++) begin
                t[i]     = t[i] ^ ext[i+1];
                ext[i]   = ext[i] ^ ext[i+1];
                ext[i+1] = ext[i+1] ^ (ext[i] & t[i]);
            end
            // unmajority sweep downward: restore a, leave sum in b
            for (int i = W - 1; i >= 0; i--) begin
                ext[i+1] = ext[i+1] ^ (ext[i] & t[i]);
                ext[i]   = ext[i] ^ ext[i+1];
                t[i]     = t[i] ^ ext[i];
            end
        end else begin
            // inverse unmajority stages, bottom to top
            for (int i = 0; i < W; i++) begin
                t[i]     = t[i] ^ ext[i];
                ext[i]   = ext[i] ^ ext[i+1];
                ext[i+1] = ext[i+1] ^ (ext[i] & t[i]);
            end
            // inverse majority stages, top to bottom
            for (int i = W - 1; i >= 0; i--) begin
                ext[i+1] = ext[i+1] ^ (ext[i] & t[i]);
                ext[i]   = ext[i] ^ ext[i+1];
                t[i]     = t[i] ^ ext[i+1];
            end
        end
        anc_o = ext[0];
        a_o   = ext[EW-1:1];
        b_o   = t;
    end
endmodule

// File: rtl/rev_unary.sv
// Single-operand reversible operations on the target word.
module rev_unary
    import rev_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  ralu_op_e     op_i,
    input  logic         rev_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] b_o
);
    localparam logic [W-1:0] ONE = W'(1);

    always_comb begin
        unique case (op_i)
            OP_NEG:  b_o = (~b_i) + ONE;
            OP_STEP: b_o = rev_i ? (b_i - ONE) : (b_i + ONE);
            OP_ROT:  b_o = rev_i ? {b_i[0], b_i[W-1:1]} : {b_i[W-2:0], b_i[W-1]};
            default: b_o = b_i;
        endcase
    end
endmodule

// File: rtl/rev_toffoli_word.sv
// Bitwise controlled-controlled-NOT across a whole word.
module rev_toffoli_word #(
    parameter int W = 8
) (
    input  logic [W-1:0] ctl_a_i,
    input  logic [W-1:0] ctl_c_i,
    input  logic [W-1:0] tgt_i,
    output logic [W-1:0] tgt_o
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        assign tgt_o[g] = tgt_i[g] ^ (ctl_a_i[g] & ctl_c_i[g]);
    end
endmodule

// File: rtl/rev_alu.sv
module rev_alu
    import rev_alu_pkg::*;
#(
    parameter int W       = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   op_i,
    input  logic         rev_i,
    input  logic         anc_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] c_i,
    output logic [W-1:0] a_o,
    output logic [W-1:0] b_o,
    output logic [W-1:0] c_o,
    output logic         anc_o,
    output logic         err_o
);
    ralu_op_e     op;
    logic [W-1:0] add_a, add_b, un_b, tof_b;
    logic         add_anc;

    logic [W-1:0] nx_a, nx_b, nx_c;
    logic         nx_anc, nx_err;

    assign op = ralu_op_e'(op_i);

    rev_maj_adder #(.W(W)) u_adder (
        .rev_i (rev_i),
        .anc_i (anc_i),
        .a_i   (a_i),
        .b_i   (b_i),
        .anc_o (add_anc),
        .a_o   (add_a),
        .b_o   (add_b)
    );

    rev_unary #(.W(W)) u_unary (
        .op_i  (op),
        .rev_i (rev_i),
        .b_i   (b_i),
        .b_o   (un_b)
    );

    rev_toffoli_word #(.W(W)) u_tof (
        .ctl_a_i (a_i),
        .ctl_c_i (c_i),
        .tgt_i   (b_i),
        .tgt_o   (tof_b)
    );

    // result selection
    always_comb begin
        nx_a   = a_i;
        nx_c   = c_i;
        nx_anc = anc_i;
        nx_err = 1'b0;
        unique case (op)
            OP_ADD: begin
                nx_a   = add_a;
                nx_b   = add_b;
                nx_anc = add_anc;
                nx_err = add_anc;
            end
            OP_NEG, OP_STEP, OP_ROT: nx_b = un_b;
            OP_TOF:                  nx_b = tof_b;
            default:                 nx_b = b_i;
        endcase
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                a_o   <= '0;
                b_o   <= '0;
                c_o   <= '0;
                anc_o <= 1'b0;
                err_o <= 1'b0;
            end else begin
                a_o   <= nx_a;
                b_o   <= nx_b;
                c_o   <= nx_c;
                anc_o <= nx_anc;
                err_o <= nx_err;
            end
        end
    end else begin : g_comb
        logic unused_clk;
        assign unused_clk = clk ^ rst_n;
        assign a_o   = nx_a;
        assign b_o   = nx_b;
        assign c_o   = nx_c;
        assign anc_o = nx_anc;
        assign err_o = nx_err;
    end
endmodule

// File: rtl/rev_alu_sva.sv
module rev_alu_sva
    import rev_alu_pkg::*;
#(
    parameter int W       = 8,
    parameter bit REG_OUT = 1'b1
) (
    input logic         clk,
    input logic         rst_n,
    input logic [2:0]   op_i,
    input logic         rev_i,
    input logic         anc_i,
    input logic [W-1:0] a_i,
    input logic [W-1:0] b_i,
    input logic [W-1:0] c_i,
    input logic [W-1:0] a_o,
    input logic [W-1:0] b_o,
    input logic [W-1:0] c_o,
    input logic         anc_o,
    input logic         err_o
);
    if (REG_OUT) begin : g_seq
        logic past_ok;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) past_ok <= 1'b0;
            else        past_ok <= 1'b1;
        end

        AST_CTRL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
            past_ok |-> (a_o == $past(a_i) && c_o == $past(c_i))); // R7
        AST_ADD_FWD: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && $past(op_i) == 3'd0 && !$past(rev_i))
            |-> b_o == W'($past(a_i) + $past(b_i) + W'($past(anc_i)))); // R1
        AST_ADD_REV: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && $past(op_i) == 3'd0 && $past(rev_i))
            |-> b_o == W'($past(b_i) - $past(a_i) - W'($past(anc_i)))); // R2
        AST_ANC_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
            past_ok |-> (anc_o == $past(anc_i))); // R8
        AST_ERR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            past_ok |-> (err_o == ($past(op_i) == 3'd0 && anc_o))); // R8
        AST_TOF_XOR: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && $past(op_i) == 3'd4)
            |-> ((b_o ^ $past(b_i)) == ($past(a_i) & $past(c_i)))); // R6
        AST_RSV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && $past(op_i) >= 3'd5) |-> (b_o == $past(b_i) && !err_o)); // R9
    end else begin : g_cmb
        AST_CTRL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
            (a_o == a_i && c_o == c_i)); // R7
        AST_ANC_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
            (anc_o == anc_i)); // R8
        AST_ADD_FWD: assert property (@(posedge clk) disable iff (!rst_n)
            (op_i == 3'd0 && !rev_i) |-> b_o == W'(a_i + b_i + W'(anc_i))); // R1
        AST_TOF_XOR: assert property (@(posedge clk) disable iff (!rst_n)
            (op_i == 3'd4) |-> ((b_o ^ b_i) == (a_i & c_i))); // R6
    end
endmodule

bind rev_alu rev_alu_sva #(.W(W), .REG_OUT(REG_OUT)) u_sva (.*);

// File: tb/test_rev_alu.sv
`timescale 1ns/1ps
module test_rev_alu;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   op_i = '0;
    logic         rev_i = 1'b0, anc_i = 1'b0;
    logic [W-1:0] a_i = '0, b_i = '0, c_i = '0;
    logic [W-1:0] a_o, b_o, c_o;
    logic         anc_o, err_o;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    rev_alu #(.W(W), .REG_OUT(1'b1)) i_rev_alu (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .rev_i(rev_i), .anc_i(anc_i),
        .a_i(a_i), .b_i(b_i), .c_i(c_i),
        .a_o(a_o), .b_o(b_o), .c_o(c_o), .anc_o(anc_o), .err_o(err_o)
    );

    // expected {a, b, c, anc, err} from the requirement text
    function automatic logic [3*W+1:0] model(input logic [2:0] op, input logic rv,
                                             input logic an, input logic [W-1:0] a,
                                             input logic [W-1:0] b, input logic [W-1:0] c);
        logic [W-1:0] nb;
        case (op)
            3'd0: nb = rv ? W'(int'(b) - int'(a) - int'(an)) : W'(int'(a) + int'(b) + int'(an));
            3'd1: nb = W'(256 - int'(b));
            3'd2: nb = rv ? W'(int'(b) + 255) : W'(int'(b) + 1);
            3'd3: nb = rv ? W'((int'(b) >> 1) + (int'(b) % 2) * 128) : W'(int'(b) * 2 + int'(b) / 128);
            3'd4: nb = b ^ (a & c);
            default: nb = b;
        endcase
        return {a, nb, c, an, (op == 3'd0) && an};
    endfunction

    task automatic check(input string tag, input logic [3*W+1:0] act, input logic [3*W+1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, result captured on the rising edge, read at the next falling edge
    task automatic run(input string tag, input logic [2:0] op, input logic rv, input logic an,
                       input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c);
        op_i = op; rev_i = rv; anc_i = an; a_i = a; b_i = b; c_i = c;
        @(negedge clk);
        check(tag, {a_o, b_o, c_o, anc_o, err_o}, model(op, rv, an, a, b, c));
    endtask

    task automatic round_trip(input logic [2:0] op, input logic rv, input logic [W-1:0] a,
                              input logic [W-1:0] b, input logic [W-1:0] c);
        logic [W-1:0] mid;
        run("R10 fwd", op, rv, 1'b0, a, b, c);
        mid = b_o;
        run("R10 back", op, !rv, 1'b0, a, mid, c);
        check("R10 restore", {{(2*W+2){1'b0}}, b_o}, {{(2*W+2){1'b0}}, b});
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : stim
        a_i = 8'hA5; b_i = 8'h5A; c_i = 8'hFF; anc_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R11 reset", {a_o, b_o, c_o, anc_o, err_o}, '0);
        rst_n = 1'b1;
        anc_i = 1'b0;
        @(negedge clk);

        // R11: one-cycle latency, output follows the new input after one edge
        op_i = 3'd2; rev_i = 1'b0; a_i = 8'h00; b_i = 8'h10; c_i = 8'h00;
        @(negedge clk);
        check("R11 latency", {24'h0, 2'b0, b_o}, {24'h0, 2'b0, 8'h11});

        // R1 / R2: every a, strided b, both directions, wrap included
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b += 5) begin
                run("R1 add", 3'd0, 1'b0, 1'b0, W'(a), W'(b), W'(a ^ 8'h3C));
                run("R2 sub", 3'd0, 1'b1, 1'b0, W'(a), W'(b), W'(b));
            end
        end
        run("R1 wrap", 3'd0, 1'b0, 1'b0, 8'hFF, 8'h01, 8'h00);
        run("R2 wrap", 3'd0, 1'b1, 1'b0, 8'h01, 8'h00, 8'h00);

        // R8: nonzero ancilla shifts the result by one and raises the flag
        for (int k = 0; k < 16; k++) begin
            run("R8 anc fwd", 3'd0, 1'b0, 1'b1, W'(k * 17), W'(k * 9 + 3), 8'h00);
            run("R8 anc rev", 3'd0, 1'b1, 1'b1, W'(k * 17), W'(k * 9 + 3), 8'h00);
            run("R8 anc other op", 3'd2, 1'b0, 1'b1, W'(k), W'(k), 8'h00);
        end

        // R3, R4, R5: all target values, both directions
        for (int b = 0; b < 256; b++) begin
            for (int rv = 0; rv < 2; rv++) begin
                run("R3 neg", 3'd1, rv[0], 1'b0, 8'h77, W'(b), 8'h11);
                run("R4 step", 3'd2, rv[0], 1'b0, 8'h00, W'(b), 8'hEE);
                run("R5 rot", 3'd3, rv[0], 1'b0, W'(b), W'(b), W'(~b));
            end
        end

        // R6: word Toffoli, rev ignored; R7 controls pass through
        for (int a = 0; a < 256; a++) begin
            run("R6 tof", 3'd4, 1'b0, 1'b0, W'(a), W'(a * 3), W'(a ^ 8'h5A));
            run("R6 tof rev ignored", 3'd4, 1'b1, 1'b0, W'(a), 8'hC3, W'(~a));
        end
        run("R7 controls", 3'd4, 1'b0, 1'b0, 8'hF0, 8'h00, 8'h0F);

        // R9: reserved codes hold b
        for (int op = 5; op < 8; op++) begin
            run("R9 reserved", W'(op) , 1'b0, 1'b0, 8'hAA, 8'h55, 8'hFF);
            run("R9 reserved rev", W'(op), 1'b1, 1'b1, 8'h12, 8'h34, 8'h56);
        end

        // R10: forward then inverse restores b
        for (int k = 0; k < 32; k++) begin
            for (int op = 0; op < 5; op++) begin
                round_trip(W'(op), k[0], W'(k * 37 + 5), W'(k * 113 + 200), W'(k * 29));
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule